// File: doc/BRIEF.md
# Double-Buffered Eight-Channel DAC Register Bank

This block keeps the digital state of an eight-channel digital-to-analog converter. Every channel owns two registers: an input (staging) register that software writes, and a DAC register whose value drives the converter. A serial front end hands the block decoded write requests, one per cycle. Staged values move into the DAC registers in one of two ways. A hardware load strobe `load_n` moves them for the channels enabled in a load mask. Software update commands move them for the channels named in a command bitmap.

A falling edge on the active-low `clear_n` input overwrites both registers of every channel with a programmable clear code. For as long as `clear_n` stays low, the load strobe has no effect. Both pins are asynchronous to the system clock, so each passes through a two-flop synchroniser. The clear pin also feeds a falling-edge detector.

A two-state machine tracks the clear. ST_RUN is the normal state. In ST_RUN a detected clear falling edge applies the clear code and moves the machine to ST_CLR_HOLD. In ST_CLR_HOLD the load strobe is blocked. The machine returns to ST_RUN once the synchronised clear level reads high again. The block also holds a 2-bit power-down mode per channel and a reference-enable flag. A build parameter chooses the value the channels take at reset, and another reduces the resolution to 12 bits.

Top module: `dac_regbank`

## Requirements
- R1: After reset, the input and DAC registers of every channel hold zero, or hold 0x8000 when POR_MID=1. Every power-down mode is 00 (normal), `ref_en` is 0, the load mask is all ones and the clear selector is 00.
- R2: Command 0 (write input) loads `wr_data` into the input register of the addressed channel. The DAC output does not change as a result.
- R3: While the synchronised `load_n` is low and the state is ST_RUN, each enabled channel's DAC register takes its input register's value. The copy happens on the third rising edge after the pin falls. When `load_n` is held low, a written input value reaches the output on the second edge after the write.
- R4: Command 4 sets the load mask from `wr_data[7:0]`, with bit i enabling channel i. A channel whose mask bit is 0 ignores the load strobe.
- R5: On the third rising edge after `clear_n` falls, the input and DAC registers of all channels take the clear code. This takes priority over any write in that cycle, and the state moves to ST_CLR_HOLD.
- R6: While the synchronised `clear_n` is low (state ST_CLR_HOLD), load strobes are ignored. Once the pin rises, the state returns to ST_RUN.
- R7: Command 5 sets the clear selector from `wr_data[1:0]`: 00 gives zero scale, 01 gives midscale (0x8000), and 10 or 11 give full scale.
- R8: Command 2 writes both registers of the addressed channel at once. Command 1 copies input to DAC for every channel i with `wr_data[i]`=1. Neither command depends on the load mask or on `load_n`.
- R9: Command 3 sets the power-down mode of every channel i with `wr_data[i]`=1 to `wr_data[9:8]`. The modes are 00 normal, 01 1 k to ground, 10 100 k to ground and 11 three-state. Channel i's mode appears on `pd_mode[2i+1:2i]`.
- R10: Command 6 sets `ref_en` to `wr_data[0]`. No other command changes `ref_en`.
- R11: With RES_BITS=12, the low four bits of every stored code are zero, including clear codes (full scale becomes 0xFFF0).
- R12: Address 0xF addresses all channels. An address of 8 to 14, and command codes 7 to 15, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A decoded write request is present this cycle |
| wr_cmd | input | 4 | Command code |
| wr_addr | input | 4 | Channel address, 0xF = all |
| wr_data | input | 16 | Code, bitmap or setting |
| load_n | input | 1 | Asynchronous active-low load strobe |
| clear_n | input | 1 | Asynchronous active-low clear, falling-edge triggered |
| dac_code | output | 128 | DAC register of channel i at bits [16i+15:16i] |
| pd_mode | output | 16 | Power-down mode of channel i at bits [2i+1:2i] |
| ref_en | output | 1 | Internal reference enable |

## Verification
The hardest case to reach is a load pulse that arrives while the clear is held low. The bench must show that the pulse has no effect, and that the staged value is still waiting afterwards. To reach it, the bench holds `clear_n` low past the synchroniser delay, writes a new input value, and pulses `load_n`. It then releases the clear and pulses the load again, so the deferred value must now appear. Randomised traffic with sparse load and clear toggles then runs against a behavioural model on every clock, in both the 16-bit and the 12-bit midscale-reset configurations.

// File: rtl/dac_rb_pkg.sv
package dac_rb_pkg;

    typedef enum logic [3:0] {
        CMD_WR_IN      = 4'd0,
        CMD_UPD_SEL    = 4'd1,
        CMD_WR_UPD     = 4'd2,
        CMD_SET_PD     = 4'd3,
        CMD_SET_LDMASK = 4'd4,
        CMD_SET_CLR    = 4'd5,
        CMD_SET_REF    = 4'd6
    } cmd_e;

    typedef enum logic {
        ST_RUN,
        ST_CLR_HOLD
    } clr_state_e;

    typedef enum logic [1:0] {
        PD_NORMAL   = 2'b00,
        PD_1K       = 2'b01,
        PD_100K     = 2'b10,
        PD_TRISTATE = 2'b11
    } pd_mode_e;

    typedef enum logic [1:0] {
        CLR_ZERO = 2'b00,
        CLR_MID  = 2'b01,
        CLR_FULL = 2'b10
    } clr_sel_e;

endpackage

// File: rtl/dac_rb_sync.sv
module dac_rb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level,
    output logic fall
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {CHAIN_W{RST_VAL}};
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], pin_in};
        end
    end

    assign level = chain_q[STAGES-1];
    assign fall  = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/dac_rb_ctrl.sv
module dac_rb_ctrl
    import dac_rb_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int CODE_W   = 16,
    parameter int ADDR_W   = 4,
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [3:0]          wr_cmd,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CODE_W-1:0]   wr_data,
    input  logic                ld_level,
    input  logic                clr_level,
    input  logic                clr_fall,
    output logic                clr_apply,
    output logic [CODE_W-1:0]   clr_value,
    output logic [NCH-1:0]      in_we,
    output logic [NCH-1:0]      dac_we,
    output logic [NCH-1:0]      copy_en,
    output logic [2*NCH-1:0]    pd_mode,
    output logic                ref_en
);
    localparam logic [ADDR_W-1:0] ADDR_ALL = '1;
    localparam logic [CODE_W-1:0] ALL_ONES = '1;
    localparam logic [CODE_W-1:0] KEEP     = ALL_ONES << (CODE_W - RES_BITS);
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    clr_state_e           state_q, state_d;
    logic [NCH-1:0]       ld_mask_q;
    logic [1:0]           clr_sel_q;
    logic                 ref_q;
    logic [2*NCH-1:0]     pd_q;
    cmd_e                 cmd;
    logic                 is_wr_in, is_wr_upd, is_upd_sel;
    logic                 is_set_pd, is_set_mask, is_set_clr, is_set_ref;
    logic [NCH-1:0]       chan_hit;

    assign cmd = cmd_e'(wr_cmd);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (clr_fall) state_d = ST_CLR_HOLD;
            end
            ST_CLR_HOLD: begin
                if (clr_level && !clr_fall) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // command decode
    always_comb begin
        is_wr_in    = wr_valid && (cmd == CMD_WR_IN);
        is_wr_upd   = wr_valid && (cmd == CMD_WR_UPD);
        is_upd_sel  = wr_valid && (cmd == CMD_UPD_SEL);
        is_set_pd   = wr_valid && (cmd == CMD_SET_PD);
        is_set_mask = wr_valid && (cmd == CMD_SET_LDMASK);
        is_set_clr  = wr_valid && (cmd == CMD_SET_CLR);
        is_set_ref  = wr_valid && (cmd == CMD_SET_REF);
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_mask_q <= '1;
            clr_sel_q <= CLR_ZERO;
            ref_q     <= 1'b0;
        end else begin
            if (is_set_mask) ld_mask_q <= wr_data[NCH-1:0];
            if (is_set_clr)  clr_sel_q <= wr_data[1:0];
            if (is_set_ref)  ref_q     <= wr_data[0];
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_pd
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pd_q[2*g +: 2] <= PD_NORMAL;
                end else if (is_set_pd && wr_data[g]) begin
                    pd_q[2*g +: 2] <= wr_data[NCH +: 2];
                end
            end
        end
    endgenerate

    // outputs
    always_comb begin
        unique case (clr_sel_q)
            CLR_ZERO: clr_value = '0;
            CLR_MID:  clr_value = MID_CODE & KEEP;
            default:  clr_value = KEEP;
        endcase
        clr_apply = clr_fall;
        for (int i = 0; i < NCH; i++) begin
            chan_hit[i] = (wr_addr == ADDR_ALL) || (wr_addr == ADDR_W'(i));
            in_we[i]    = (is_wr_in || is_wr_upd) && chan_hit[i];
            dac_we[i]   = is_wr_upd && chan_hit[i];
            copy_en[i]  = (is_upd_sel && wr_data[i])
                        || ((state_q == ST_RUN) && !clr_fall && !ld_level && ld_mask_q[i]);
        end
        pd_mode = pd_q;
        ref_en  = ref_q;
    end

    AST_CLR_ENTERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fall |=> (state_q == ST_CLR_HOLD));                                  // R5
    AST_HOLD_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLR_HOLD && clr_level && !clr_fall) |=> (state_q == ST_RUN)); // R6
    AST_REF_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_set_ref |=> $stable(ref_en));                                        // R10
    AST_PD_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_set_pd |=> $stable(pd_mode));                                        // R9

endmodule

// File: rtl/dac_rb_chan.sv
module dac_rb_chan #(
    parameter int                CODE_W   = 16,
    parameter logic [CODE_W-1:0] KEEP     = '1,
    parameter logic [CODE_W-1:0] RST_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_now,
    input  logic [CODE_W-1:0] clear_val,
    input  logic              in_we,
    input  logic              dac_we,
    input  logic              copy_en,
    input  logic [CODE_W-1:0] data,
    output logic [CODE_W-1:0] dac_q
);
    logic [CODE_W-1:0] in_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q  <= RST_CODE;
            dac_q <= RST_CODE;
        end else if (clear_now) begin
            in_q  <= clear_val;
            dac_q <= clear_val;
        end else begin
            if (in_we) begin
                in_q <= data & KEEP;
            end
            if (dac_we) begin
                dac_q <= data & KEEP;
            end else if (copy_en) begin
                dac_q <= in_q;
            end
        end
    end

    AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        clear_now |=> (in_q == $past(clear_val) && dac_q == $past(clear_val)));  // R5
    AST_COPY_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_now && !dac_we && copy_en) |=> (dac_q == $past(in_q)));          // R3
    AST_DAC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_now && !dac_we && !copy_en) |=> $stable(dac_q));                 // R2

endmodule

// File: rtl/dac_regbank.sv
module dac_regbank #(
    parameter int NCH         = 8,
    parameter int CODE_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int RES_BITS    = 16,
    parameter bit POR_MID     = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic [3:0]            wr_cmd,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CODE_W-1:0]     wr_data,
    input  logic                  load_n,
    input  logic                  clear_n,
    output logic [NCH*CODE_W-1:0] dac_code,
    output logic [2*NCH-1:0]      pd_mode,
    output logic                  ref_en
);
    localparam logic [CODE_W-1:0] ALL_ONES = '1;
    localparam logic [CODE_W-1:0] KEEP     = ALL_ONES << (CODE_W - RES_BITS);
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] RST_CODE = POR_MID ? MID_CODE : '0;

    logic              ld_level, ld_fall_unused;
    logic              clr_level, clr_fall;
    logic              clr_apply;
    logic [CODE_W-1:0] clr_value;
    logic [NCH-1:0]    in_we, dac_we, copy_en;

    dac_rb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ld_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(load_n),
        .level(ld_level), .fall(ld_fall_unused)
    );

    dac_rb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_clr_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(clear_n),
        .level(clr_level), .fall(clr_fall)
    );

    dac_rb_ctrl #(.NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .RES_BITS(RES_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_cmd(wr_cmd), .wr_addr(wr_addr), .wr_data(wr_data),
        .ld_level(ld_level), .clr_level(clr_level), .clr_fall(clr_fall),
        .clr_apply(clr_apply), .clr_value(clr_value),
        .in_we(in_we), .dac_we(dac_we), .copy_en(copy_en),
        .pd_mode(pd_mode), .ref_en(ref_en)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chan
            dac_rb_chan #(.CODE_W(CODE_W), .KEEP(KEEP), .RST_CODE(RST_CODE)) u_chan (
                .clk(clk), .rst_n(rst_n),
                .clear_now(clr_apply), .clear_val(clr_value),
                .in_we(in_we[g]), .dac_we(dac_we[g]), .copy_en(copy_en[g]),
                .data(wr_data),
                .dac_q(dac_code[g*CODE_W +: CODE_W])
            );

            always_ff @(posedge clk) begin
                if (rst_n) begin
                    AST_LOW_BITS_ZERO: assert ((dac_code[g*CODE_W +: CODE_W] & ~KEEP) == '0); // R11
                end
            end
        end
    endgenerate

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_level && !clr_fall && !wr_valid) |=> $stable(dac_code));           // R6

endmodule

// File: tb/sim_dac_regbank.sv
module sim_dac_regbank;
    localparam int NCH = 8;
    localparam int CW  = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [3:0]    wr_cmd = '0;
    logic [3:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          load_n = 1'b1;
    logic          clear_n = 1'b1;
    logic [NCH*CW-1:0] dac0, dac1;
    logic [2*NCH-1:0]  pd0, pd1;
    logic              ref0, ref1;

    dac_regbank u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_cmd(wr_cmd),
        .wr_addr(wr_addr), .wr_data(wr_data), .load_n(load_n), .clear_n(clear_n),
        .dac_code(dac0), .pd_mode(pd0), .ref_en(ref0)
    );

    dac_regbank #(.RES_BITS(12), .POR_MID(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_cmd(wr_cmd),
        .wr_addr(wr_addr), .wr_data(wr_data), .load_n(load_n), .clear_n(clear_n),
        .dac_code(dac1), .pd_mode(pd1), .ref_en(ref1)
    );

    int checks = 0;
    int fails  = 0;
    string phase = "R1";
    bit done = 0;

    // behavioural reference model
    logic [15:0] m_in [2][NCH];
    logic [15:0] m_dac[2][NCH];
    logic [15:0] keep [2] = '{16'hFFFF, 16'hFFF0};
    logic [15:0] rstv [2] = '{16'h0000, 16'h8000};
    logic [1:0]  m_pd [NCH];
    logic        m_ref, m_hold, m_ok = 0;
    logic [7:0]  m_mask;
    logic [1:0]  m_clr;
    logic        ld1, ld2, cl1, cl2, cl3;
    logic        fall, ldact, hit;
    logic [15:0] cv;

    always @(posedge clk) begin
        m_ok = 1;
        if (!rst_n) begin
            for (int k = 0; k < 2; k++)
                for (int i = 0; i < NCH; i++) begin
                    m_in[k][i] = rstv[k]; m_dac[k][i] = rstv[k];
                end
            for (int i = 0; i < NCH; i++) m_pd[i] = 2'b00;
            m_ref = 0; m_hold = 0; m_mask = 8'hFF; m_clr = 2'b00;
            ld1 = 1; ld2 = 1; cl1 = 1; cl2 = 1; cl3 = 1;
        end else begin
            fall  = cl3 && !cl2;
            ldact = !m_hold && !fall && !ld2;
            for (int k = 0; k < 2; k++) begin
                cv = (m_clr == 2'b00) ? 16'h0000 : (m_clr == 2'b01) ? 16'h8000 : 16'hFFFF;
                cv = cv & keep[k];
                for (int i = 0; i < NCH; i++) begin
                    hit = wr_valid && (wr_addr == 4'hF || wr_addr == i);
                    if (fall) begin
                        m_in[k][i] = cv; m_dac[k][i] = cv;
                    end else begin
                        if (hit && wr_cmd == 2)
                            m_dac[k][i] = wr_data & keep[k];
                        else if ((wr_valid && wr_cmd == 1 && wr_data[i]) || (ldact && m_mask[i]))
                            m_dac[k][i] = m_in[k][i];
                        if (hit && (wr_cmd == 0 || wr_cmd == 2))
                            m_in[k][i] = wr_data & keep[k];
                    end
                end
            end
            if (wr_valid && wr_cmd == 3)
                for (int i = 0; i < NCH; i++) if (wr_data[i]) m_pd[i] = wr_data[9:8];
            if (wr_valid && wr_cmd == 4) m_mask = wr_data[7:0];
            if (wr_valid && wr_cmd == 5) m_clr  = wr_data[1:0];
            if (wr_valid && wr_cmd == 6) m_ref  = wr_data[0];
            if (fall) m_hold = 1;
            else if (m_hold && cl2) m_hold = 0;
            cl3 = cl2; cl2 = cl1; cl1 = clear_n;
            ld2 = ld1; ld1 = load_n;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (m_ok && !done) begin
            for (int k = 0; k < 2; k++) begin
                bit bad = 0;
                for (int i = 0; i < NCH; i++) begin
                    logic [15:0] a;
                    a = (k == 0) ? dac0[i*CW +: CW] : dac1[i*CW +: CW];
                    if (a !== m_dac[k][i]) begin
                        bad = 1;
                        $display("FAIL %s model u%0d ch%0d dac actual %h expected %h", phase, k, i, a, m_dac[k][i]);
                    end
                    if (((k == 0) ? pd0[2*i +: 2] : pd1[2*i +: 2]) !== m_pd[i]) begin
                        bad = 1;
                        $display("FAIL %s model u%0d ch%0d pd actual %b expected %b", phase, k, i,
                                 (k == 0) ? pd0[2*i +: 2] : pd1[2*i +: 2], m_pd[i]);
                    end
                end
                if (((k == 0) ? ref0 : ref1) !== m_ref) begin
                    bad = 1;
                    $display("FAIL %s model u%0d ref_en actual %b expected %b", phase, k,
                             (k == 0) ? ref0 : ref1, m_ref);
                end
                checks++;
                if (bad) fails++;
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_valid = 1; wr_cmd = c; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic pulse_load();
        @(negedge clk); load_n = 0; idle(3); load_n = 1; idle(4);
    endtask

    task automatic pulse_clear();
        @(negedge clk); clear_n = 0; idle(4); clear_n = 1; idle(4);
    endtask

    function automatic logic [15:0] ch0(input int i); return dac0[i*CW +: CW]; endfunction
    function automatic logic [15:0] ch1(input int i); return dac1[i*CW +: CW]; endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        phase = "R1";
        chk("R1 u0 dac3 reset", ch0(3), 16'h0000);
        chk("R1 u1 dac3 reset mid", ch1(3), 16'h8000);
        chk("R1 pd reset", pd0, 16'h0000);
        chk("R1 ref reset", {15'd0, ref0}, 16'h0000);
        rst_n = 1;
        idle(2);

        phase = "R2";
        cmd(0, 2, 16'h1234);
        idle(4);
        chk("R2 staged write hidden", ch0(2), 16'h0000);

        phase = "R3";
        pulse_load();
        chk("R3 load copies", ch0(2), 16'h1234);
        chk("R11 12-bit copy", ch1(2), 16'h1230);

        phase = "R4";
        cmd(4, 0, 16'h00FE);
        cmd(0, 0, 16'hAAAA);
        cmd(0, 1, 16'h5555);
        pulse_load();
        chk("R4 masked channel ignores load", ch0(0), 16'h0000);
        chk("R4 enabled channel loads", ch0(1), 16'h5555);

        phase = "R3";
        @(negedge clk); load_n = 0;
        idle(3);
        cmd(0, 1, 16'h0777);
        idle(2);
        chk("R3 load tied low passes through", ch0(1), 16'h0777);
        load_n = 1;
        idle(3);

        phase = "R5";
        cmd(5, 0, 16'h0001);
        pulse_clear();
        chk("R5 clear sets dac to mid", ch0(6), 16'h8000);
        chk("R7 mid code 12-bit", ch1(6), 16'h8000);
        cmd(4, 0, 16'h00FF);
        pulse_load();
        chk("R5 clear reached input register", ch0(0), 16'h8000);

        phase = "R6";
        @(negedge clk); clear_n = 0;
        idle(5);
        cmd(0, 3, 16'h4444);
        pulse_load();
        chk("R6 load ignored while clear low", ch0(3), 16'h8000);
        clear_n = 1;
        idle(5);
        chk("R6 still held after release", ch0(3), 16'h8000);
        pulse_load();
        chk("R6 deferred load after release", ch0(3), 16'h4444);

        phase = "R7";
        cmd(5, 0, 16'h0002);
        pulse_clear();
        chk("R7 full scale", ch0(4), 16'hFFFF);
        chk("R11 full scale 12-bit", ch1(4), 16'hFFF0);
        cmd(5, 0, 16'h0003);
        pulse_clear();
        chk("R7 code 11 full scale", ch0(4), 16'hFFFF);
        cmd(5, 0, 16'h0000);
        pulse_clear();
        chk("R7 zero scale", ch0(4), 16'h0000);

        phase = "R8";
        cmd(4, 0, 16'h0000);
        cmd(2, 5, 16'h2468);
        chk("R8 write and update", ch0(5), 16'h2468);
        cmd(0, 6, 16'h1357);
        pulse_load();
        chk("R4 mask zero blocks load", ch0(6), 16'h0000);
        cmd(1, 0, 16'h0040);
        chk("R8 software update bitmap", ch0(6), 16'h1357);

        phase = "R9";
        cmd(3, 0, 16'h0381);
        chk("R9 pd three-state ch0 ch7", pd0, 16'hC003);
        cmd(3, 0, 16'h0101);
        chk("R9 pd 1k ch0", pd0, 16'hC001);

        phase = "R10";
        cmd(6, 0, 16'h0001);
        chk("R10 ref on", {15'd0, ref0}, 16'h0001);
        cmd(6, 0, 16'h0000);
        chk("R10 ref off", {15'd0, ref0}, 16'h0000);

        phase = "R12";
        cmd(2, 4'hF, 16'h0F0F);
        chk("R12 broadcast", ch0(7), 16'h0F0F);
        chk("R12 broadcast 12-bit", ch1(0), 16'h0F00);
        cmd(2, 9, 16'h1111);
        chk("R12 out of range address", ch0(1), 16'h0F0F);
        cmd(9, 0, 16'h2222);
        chk("R12 unused command", ch0(0), 16'h0F0F);

        phase = "R2";
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            wr_valid = ($urandom % 3) != 0;
            wr_cmd   = 4'($urandom % 10);
            wr_addr  = (($urandom % 6) == 0) ? 4'hF : 4'($urandom % 10);
            wr_data  = 16'($urandom);
            if (($urandom % 9) == 0) load_n  = ~load_n;
            if (($urandom % 23) == 0) clear_n = ~clear_n;
        end
        @(negedge clk);
        wr_valid = 0; load_n = 1; clear_n = 1;
        idle(6);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule